// File: doc/BRIEF.md
# Chip-Select Configuration Register Block with Unlock Key

This block holds the timing and access settings for four external chip selects. It also holds a lock that guards them. Software reaches the block over a plain synchronous register bus. The bus carries a byte address, a 32-bit write word, a write strobe, a read strobe and a registered read word. Each chip select has one 8-bit configuration register. The register's fields are decoded and driven on parallel outputs, which the external memory controller samples. The outputs are a 4-bit wait code, a sync/async flag, a write-permission flag and a 2-bit data-width code.

All chip-select registers start out protected. A write to a chip-select register is discarded until the unlock key 0x0000A05F has been written to the lock register at byte offset 0x20. Writing any other word there protects the registers again. The register bus is a control path with no data stream. It has no valid/ready pair and no back-pressure: every strobe completes in the cycle it is sampled.

Top module: `csel_cfg_regs`

## Requirements
- R1: After reset the block is locked, all four chip-select registers read 0x00 and every field output is 0.
- R2: A read of byte offset 0x20 returns 1 in bit 0 while locked and 0 while unlocked; all other bits read 0.
- R3: A write of exactly 0x0000A05F to offset 0x20 unlocks the block, and it takes effect for accesses from the next cycle.
- R4: A write of any other word to offset 0x20, including one that matches only in the low 16 bits, locks the block.
- R5: A write to a chip-select register while locked is dropped: its read-back value and its field outputs do not change.
- R6: Chip selects 0 to 3 sit at byte offsets 0x00, 0x04, 0x08 and 0x0C. While unlocked, a write stores bits 7:0 of the write word, and a read returns the stored byte in bits 7:0 with bits 31:8 at 0.
- R7: The outputs for chip select n are driven from its register: the wait code from bits 7:4, sync from bit 3 (1 = synchronous) and write permission from bit 2 (1 = writes allowed). A write is visible on these outputs right after the clock edge that samples it.
- R8: Bits 1:0 select the data width (00 = 8-bit, 01 = 16-bit, 10 = 32-bit) and go out unchanged. Code 11 goes out as 10 (32-bit), while a read still returns the stored 11.
- R9: Read data is registered and appears after the edge that samples the read strobe. It is 0 after any edge where the read strobe is low. Addresses other than the five mapped word offsets, including misaligned ones, read 0, and writes to them have no effect.
- R10: When a read and a write to the same chip-select register are sampled at the same edge, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write word |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read word |
| cs_wait | output | 16 | Wait code, 4 bits per chip select, chip select 0 in bits 3:0 |
| cs_sync | output | 4 | Synchronous-memory flag per chip select |
| cs_wr_ok | output | 4 | Write permission per chip select |
| cs_width | output | 8 | Data-width code, 2 bits per chip select, code 11 folded to 10 |

## Verification
Every result of this block is due exactly one clock edge after its stimulus:
- Field outputs follow a chip-select write after the edge that samples it.
- Read data appears after the edge that samples the read strobe and clears after the next edge if the strobe is low.
- A lock-register write changes what the following access sees.

The bench drives each access half a cycle before an edge and compares at the falling edge after it. That is one edge later, the cycle the requirement names. Expected values come from a byte model of the four registers and the lock flag. The model is updated by the write rules above, and the read for a simultaneous read-and-write is computed before the model applies the write.

// File: rtl/csel_cfg_pkg.sv
package csel_cfg_pkg;
  localparam int unsigned CFG_W = 8;
  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;

  // Bit layout of a chip-select configuration byte.
  typedef struct packed {
    logic [3:0] wait_code;  // 7:4
    logic       sync;       // 3
    logic       wr_ok;      // 2
    logic [1:0] width;      // 1:0
  } cs_cfg_t;

  localparam logic [1:0] WIDTH_8  = 2'b00;
  localparam logic [1:0] WIDTH_16 = 2'b01;
  localparam logic [1:0] WIDTH_32 = 2'b10;
  localparam logic [1:0] WIDTH_RSV = 2'b11;
endpackage

// File: rtl/csel_key_gate.sv
module csel_key_gate
  import csel_cfg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  output logic              unlocked
);
  localparam logic [DATA_W-1:0] KEY_WORD = DATA_W'(UNLOCK_KEY);

  logic unlocked_q;
  logic key_match;

  assign key_match = (key_data == KEY_WORD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
    end else if (key_wr) begin
      unlocked_q <= key_match;
    end
  end

  assign unlocked = unlocked_q;
endmodule

// File: rtl/csel_slot_reg.sv
module csel_slot_reg
  import csel_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_byte,
  output logic [CFG_W-1:0] cfg_raw,
  output logic [3:0]       wait_o,
  output logic             sync_o,
  output logic             wr_ok_o,
  output logic [1:0]       width_o
);
  cs_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q <= cs_cfg_t'(wr_byte);
    end
  end

  assign cfg_raw = cfg_q;
  assign wait_o  = cfg_q.wait_code;
  assign sync_o  = cfg_q.sync;
  assign wr_ok_o = cfg_q.wr_ok;

  // The reserved width code is presented to the memory side as 32-bit.
  always_comb begin
    unique case (cfg_q.width)
      WIDTH_8:   width_o = WIDTH_8;
      WIDTH_16:  width_o = WIDTH_16;
      WIDTH_32:  width_o = WIDTH_32;
      default:   width_o = WIDTH_32;
    endcase
  end
endmodule

// File: rtl/csel_read_mux.sv
module csel_read_mux
  import csel_cfg_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_en,
  input  logic [NUM_CS-1:0]            sel_cs,
  input  logic                         sel_lock,
  input  logic [NUM_CS-1:0][CFG_W-1:0] slot_raw,
  input  logic                         locked,
  output logic [DATA_W-1:0]            rdata
);
  logic [DATA_W-1:0] rd_next;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    rd_next = '0;
    if (sel_lock) rd_next = DATA_W'(locked);
    for (int i = 0; i < NUM_CS; i++) begin
      if (sel_cs[i]) rd_next = DATA_W'(slot_raw[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rd_en ? rd_next : '0;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/csel_cfg_regs.sv
module csel_cfg_regs
  import csel_cfg_pkg::*;
#(
  parameter int unsigned NUM_CS    = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CS_STRIDE = 4,
  parameter int unsigned LOCK_OFS  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic                  bus_we,
  input  logic                  bus_re,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [NUM_CS*4-1:0]   cs_wait,
  output logic [NUM_CS-1:0]     cs_sync,
  output logic [NUM_CS-1:0]     cs_wr_ok,
  output logic [NUM_CS*2-1:0]   cs_width
);
  localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(LOCK_OFS);

  logic [NUM_CS-1:0]            hit_cs;
  logic                         hit_lock;
  logic                         unlocked;
  logic [NUM_CS-1:0][CFG_W-1:0] slot_raw;

  assign hit_lock = (bus_addr == LOCK_ADDR);

  csel_key_gate #(.DATA_W(DATA_W)) u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (bus_we && hit_lock),
    .key_data (bus_wdata),
    .unlocked (unlocked)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_slot
    assign hit_cs[g] = (bus_addr == ADDR_W'(g * CS_STRIDE));

    csel_slot_reg u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_we && hit_cs[g] && unlocked),
      .wr_byte (bus_wdata[CFG_W-1:0]),
      .cfg_raw (slot_raw[g]),
      .wait_o  (cs_wait[g*4 +: 4]),
      .sync_o  (cs_sync[g]),
      .wr_ok_o (cs_wr_ok[g]),
      .width_o (cs_width[g*2 +: 2])
    );
  end

  csel_read_mux #(.NUM_CS(NUM_CS), .DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (bus_re),
    .sel_cs   (hit_cs),
    .sel_lock (hit_lock),
    .slot_raw (slot_raw),
    .locked   (!unlocked),
    .rdata    (bus_rdata)
  );
endmodule

// File: rtl/csel_cfg_chk.sv
module csel_cfg_chk #(
  parameter int unsigned NUM_CS    = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CS_STRIDE = 4,
  parameter int unsigned LOCK_OFS  = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic                bus_we,
  input logic                bus_re,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NUM_CS*4-1:0] cs_wait,
  input logic [NUM_CS-1:0]   cs_sync,
  input logic [NUM_CS-1:0]   cs_wr_ok,
  input logic [NUM_CS*2-1:0] cs_width,
  input logic                unlocked
);
  localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(LOCK_OFS);
  localparam logic [DATA_W-1:0] KEY_W  = DATA_W'(16'hA05F);

  // R3
  key_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == LOCK_A && bus_wdata == KEY_W |=> unlocked);

  // R4
  bad_key_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == LOCK_A && bus_wdata != KEY_W |=> !unlocked);

  // R4
  lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == LOCK_A) |=> $stable(unlocked));

  // R5
  locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && !unlocked |=> $stable(cs_wait) && $stable(cs_sync)
                            && $stable(cs_wr_ok) && $stable(cs_width));

  // R2
  lock_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && bus_addr == LOCK_A |=> bus_rdata == DATA_W'(!$past(unlocked)));

  // R9
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> bus_rdata == '0);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_slot_chk
    // R7
    wait_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && unlocked && bus_addr == ADDR_W'(g * CS_STRIDE)
      |=> cs_wait[g*4 +: 4] == $past(bus_wdata[7:4])
          && cs_sync[g] == $past(bus_wdata[3])
          && cs_wr_ok[g] == $past(bus_wdata[2]));

    // R8
    width_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_width[g*2 +: 2] != 2'b11);
  end
endmodule

bind csel_cfg_regs csel_cfg_chk #(
  .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .CS_STRIDE(CS_STRIDE), .LOCK_OFS(LOCK_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
  .cs_wait(cs_wait), .cs_sync(cs_sync), .cs_wr_ok(cs_wr_ok),
  .cs_width(cs_width), .unlocked(unlocked)
);

// File: tb/csel_cfg_regs_bench.sv
`timescale 1ns/1ps
module csel_cfg_regs_bench;
  localparam logic [31:0] KEY = 32'h0000A05F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [15:0] cs_wait;
  logic [3:0]  cs_sync;
  logic [3:0]  cs_wr_ok;
  logic [7:0]  cs_width;

  always #2.5 clk = ~clk;

  csel_cfg_regs u_csel_cfg_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .cs_wait(cs_wait), .cs_sync(cs_sync), .cs_wr_ok(cs_wr_ok),
    .cs_width(cs_width)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] mdl_reg [4];
  bit mdl_unl;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] fold_w(input logic [1:0] c);
    return (c == 2'b11) ? 2'b10 : c;
  endfunction

  function automatic int cs_index(input logic [7:0] a);
    for (int i = 0; i < 4; i++) if (a == 8'(i * 4)) return i;
    return -1;
  endfunction

  function automatic logic [31:0] mdl_read(input logic [7:0] a);
    int k = cs_index(a);
    if (k >= 0) return {24'h0, mdl_reg[k]};
    if (a == 8'h20) return {31'h0, !mdl_unl};
    return 32'h0;
  endfunction

  task automatic mdl_write(input logic [7:0] a, input logic [31:0] d);
    int k = cs_index(a);
    if (a == 8'h20) mdl_unl = (d == KEY);
    else if (k >= 0 && mdl_unl) mdl_reg[k] = d[7:0];
  endtask

  task automatic check_fields(input string ctx);
    logic [15:0] ew;
    logic [3:0] es, eo;
    logic [7:0] ewd;
    for (int i = 0; i < 4; i++) begin
      ew[i*4 +: 4] = mdl_reg[i][7:4];
      es[i]        = mdl_reg[i][3];
      eo[i]        = mdl_reg[i][2];
      ewd[i*2 +: 2] = fold_w(mdl_reg[i][1:0]);
    end
    chk({"R7 wait ", ctx}, 32'(cs_wait), 32'(ew));
    chk({"R7 sync ", ctx}, 32'(cs_sync), 32'(es));
    chk({"R7 wr_ok ", ctx}, 32'(cs_wr_ok), 32'(eo));
    chk({"R8 width ", ctx}, 32'(cs_width), 32'(ewd));
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d, input string ctx);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; bus_re = 1'b0;
    @(negedge clk);
    bus_we = 1'b0;
    mdl_write(a, d);
    check_fields(ctx);
  endtask

  task automatic do_read(input logic [7:0] a, input string ctx);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1; bus_we = 1'b0;
    @(negedge clk);
    bus_re = 1'b0;
    chk(ctx, bus_rdata, mdl_read(a));
  endtask

  task automatic do_rw(input logic [7:0] a, input logic [31:0] d, input string ctx);
    logic [31:0] exp;
    exp = mdl_read(a);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; bus_re = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
    chk(ctx, bus_rdata, exp);
    mdl_write(a, d);
    check_fields(ctx);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] amap [8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h20, 8'h10, 8'h02, 8'h24};
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) mdl_reg[i] = 8'h00;
    mdl_unl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    @(negedge clk);
    check_fields("R1 reset");
    chk("R1 rdata after reset", bus_rdata, 32'h0);
    do_read(8'h20, "R1 R2 locked after reset");
    for (int i = 0; i < 4; i++) do_read(8'(i * 4), "R1 cs reg zero");
    // R5: locked write dropped
    do_write(8'h04, 32'hFF, "R5 locked write");
    do_read(8'h04, "R5 locked readback");
    // R4: wrong key keeps locked
    do_write(8'h20, 32'h1234, "R4 wrong key");
    do_read(8'h20, "R4 still locked");
    // R3: key unlocks
    do_write(8'h20, KEY, "R3 key");
    do_read(8'h20, "R3 R2 unlocked reads 0");
    // R6 R7 R8: each width code
    do_write(8'h00, 32'hFFFF_FF30, "R6 cs0");
    do_write(8'h04, 32'h59, "R6 cs1");
    do_write(8'h08, 32'hA6, "R6 cs2");
    do_write(8'h0C, 32'hFF, "R8 cs3 code 11");
    for (int i = 0; i < 4; i++) do_read(8'(i * 4), "R6 readback raw");
    // R4: match only in low half locks
    do_write(8'h20, 32'h0001A05F, "R4 partial key");
    do_read(8'h20, "R4 partial key locks");
    do_write(8'h08, 32'h11, "R5 drop after relock");
    do_read(8'h08, "R5 readback after relock");
    // R9: unmapped and misaligned
    do_write(8'h20, KEY, "R3 reopen");
    do_write(8'h10, 32'h77, "R9 unmapped write");
    do_write(8'h02, 32'h77, "R9 misaligned write");
    do_read(8'h10, "R9 unmapped read");
    do_read(8'h02, "R9 misaligned read");
    for (int i = 0; i < 4; i++) do_read(8'(i * 4), "R9 regs intact");
    // R10: simultaneous read and write
    do_rw(8'h0C, 32'h42, "R10 read old value");
    do_read(8'h0C, "R10 new value stored");
    // R9: rdata clears when read strobe low
    do_read(8'h04, "R9 read before idle");
    @(negedge clk);
    chk("R9 rdata zero when idle", bus_rdata, 32'h0);
    // Random mix
    for (int n = 0; n < 500; n++) begin
      logic [7:0] a;
      logic [31:0] d;
      int op;
      a = amap[$urandom_range(0, 7)];
      d = $urandom();
      op = $urandom_range(0, 9);
      if (op < 2) do_write(8'h20, ($urandom_range(0, 1) != 0) ? KEY : d, "R3 R4 random lock");
      else if (op < 5) do_write(a, d, "R5 R6 random write");
      else if (op < 8) do_read(a, "R2 R6 R9 random read");
      else do_rw(a, d, "R10 random rw");
    end
    done = 1;
    summary();
    $finish;
  end
endmodule